// File: doc/BRIEF.md
# Page Permission Checker with Fault Capture

This block sits beside a memory port and judges every access that falls inside a fixed, page-aligned address window. Each page of the window owns a permission word held in a small register array. The word grants read, write and execute rights separately for user and for supervisor requesters. It also carries one extra enable that the local CPU needs before it may touch the page. Accesses outside the window are not checked.

An access is denied when the right that matches its type and privilege level is missing, or when it comes from the local CPU and the page's local enable is clear. A denied access raises a one-cycle fault pulse on the next clock edge. The first denied access is also captured: its address and a syndrome (access type, privilege, local flag) stay in two readable registers until software writes the clear register. Software reaches the table and the capture registers through a plain register bus: a write strobe, an address, write data and a combinational read port.

Top module: `page_perm_checker`

## Requirements
- R1: After reset every permission word reads 0, the fault address and fault status registers read 0, and `fault_pulse` is low.
- R2: Register bus map: with `cfg_addr[6]` = 0 the low bits select a page's permission word (pages 0 to NPAGES-1; higher slots read 0 and ignore writes). Permission word layout: bit 0 user execute, bit 1 user write, bit 2 user read, bit 3 supervisor execute, bit 4 supervisor write, bit 5 supervisor read, bit 8 local CPU enable. All other bits read 0 and ignore writes.
- R3: A user access (`acc_super` = 0) is judged on bits 2:0. Access type codes: 0 read, 1 write, 2 execute. Code 3 is always denied.
- R4: A supervisor access (`acc_super` = 1) is judged on bits 5:3 with the same type codes.
- R5: An access with `acc_local` = 1 is denied when bit 8 of the page's word is clear, even if the mode bits allow it. An access with `acc_local` = 0 does not depend on bit 8.
- R6: A denied access inside the window drives `fault_pulse` high for exactly the cycle after the access. A granted access leaves it low.
- R7: An access whose address lies below WIN_BASE or at or above WIN_BASE + NPAGES*2^PAGE_LG never faults and is never captured.
- R8: Control registers use `cfg_addr[6]` = 1 with low bits 0 for the fault address and 1 for the fault status. The status layout is bits 1:0 type, bit 2 supervisor, bit 3 local, bit 4 capture held. The first denied access while nothing is held is captured. Later denied accesses leave both registers unchanged.
- R9: A write to control slot 2 zeroes the fault address and status. A denied access in the same cycle as that write is captured afresh.
- R10: An access in the same cycle as a write to its page's word is judged on the old word. The new word applies from the next cycle.
- R11: The page index is the offset from WIN_BASE shifted right by PAGE_LG. The last byte of the window uses the last page's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | AW | Access byte address |
| acc_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| acc_super | input | 1 | Requester is supervisor |
| acc_local | input | 1 | Requester is the local CPU |
| fault_pulse | output | 1 | One-cycle denied-access event |

## Verification
The bench builds the checker with 16 pages of 256 bytes at base 0x1000. That puts both window edges, the last page and the unused table slots above page 15 within a handful of accesses. The small page count keeps the aliasing of table slots 16 to 63 observable. The short pages let out-of-window addresses sit right next to the window on both sides.

// File: rtl/page_perm_checker.sv
module page_perm_checker #(
  parameter int          AW       = 32,
  parameter logic [31:0] WIN_BASE = 32'h0080_0000,
  parameter int          PAGE_LG  = 12,
  parameter int          NPAGES   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [6:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic          acc_super,
  input  logic          acc_local,
  output logic          fault_pulse
);
  localparam int PG_W = $clog2(NPAGES);
  localparam int HI   = PAGE_LG + PG_W;

  logic [8:0]    perm_q [NPAGES];
  logic [AW-1:0] far_q;
  logic [3:0]    fsr_q;
  logic          held_q;

  logic [AW-1:0] offset;
  logic          in_win;
  logic [PG_W-1:0] page;
  logic [8:0]    pw;
  logic          mode_ok, allow, deny;

  assign offset = acc_addr - AW'(WIN_BASE);
  assign in_win = (acc_addr >= AW'(WIN_BASE)) && (offset[AW-1:HI] == '0);
  assign page   = offset[PAGE_LG +: PG_W];
  assign pw     = perm_q[page];

  always_comb begin
    case (acc_kind)
      2'd0:    mode_ok = acc_super ? pw[5] : pw[2];
      2'd1:    mode_ok = acc_super ? pw[4] : pw[1];
      2'd2:    mode_ok = acc_super ? pw[3] : pw[0];
      default: mode_ok = 1'b0;
    endcase
  end

  assign allow = mode_ok && (!acc_local || pw[8]);
  assign deny  = acc_valid && in_win && !allow;

  logic tbl_sel, ctl_sel, clr_hit;
  assign tbl_sel = !cfg_addr[6] && (cfg_addr[5:0] < 6'(NPAGES));
  assign ctl_sel = cfg_addr[6] && (cfg_addr[5:2] == 4'd0);
  assign clr_hit = cfg_we && ctl_sel && (cfg_addr[1:0] == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGES; i++) perm_q[i] <= '0;
    end else if (cfg_we && tbl_sel) begin
      perm_q[cfg_addr[PG_W-1:0]] <= {cfg_wdata[8], 2'b00, cfg_wdata[5:0]};
    end
  end

  logic held_n;
  assign held_n = clr_hit ? 1'b0 : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_q       <= '0;
      fsr_q       <= '0;
      held_q      <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      fault_pulse <= deny;
      if (deny && !held_n) begin
        far_q  <= acc_addr;
        fsr_q  <= {acc_local, acc_super, acc_kind};
        held_q <= 1'b1;
      end else if (clr_hit) begin
        far_q  <= '0;
        fsr_q  <= '0;
        held_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (tbl_sel)
      cfg_rdata[8:0] = perm_q[cfg_addr[PG_W-1:0]];
    else if (ctl_sel) begin
      case (cfg_addr[1:0])
        2'd0:    cfg_rdata = 32'(far_q);
        2'd1:    cfg_rdata = {27'd0, held_q, fsr_q};
        default: cfg_rdata = '0;
      endcase
    end
  end

  assert_outside_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !in_win) |=> !fault_pulse);

  assert_capture_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr_hit) |=> ($stable(far_q) && $stable(fsr_q) && held_q));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !deny) |=> (!held_q && cfg_rdata[31:9] == '0 || !held_q));

  assert_pulse_leaves_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> held_q);

  assert_local_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && in_win && acc_local && !pw[8]) |=> fault_pulse);
endmodule

// File: tb/page_perm_checker_tb_top.sv
`timescale 1ns/1ps
module page_perm_checker_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int PLG = 8;
  localparam int NP = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [6:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic acc_valid = 0, acc_super = 0, acc_local = 0;
  logic [AW-1:0] acc_addr = 0;
  logic [1:0] acc_kind = 0;
  logic fault_pulse;

  always #2.5 clk = ~clk;

  page_perm_checker #(.AW(AW), .WIN_BASE(BASE), .PAGE_LG(PLG), .NPAGES(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_super(acc_super),
    .acc_local(acc_local), .fault_pulse(fault_pulse));

  int n_tests = 0, n_fail = 0;
  bit exp_q[$];
  int req_q[$];
  logic [8:0] m_perm [NP];
  logic [31:0] m_far = 0;
  logic [4:0] m_fsr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      automatic bit e = exp_q.pop_front();
      automatic int r = req_q.pop_front();
      check($sformatf("R%0d fault_pulse", r), 32'(fault_pulse), 32'(e));
    end
  end

  function automatic bit model_deny(input logic [31:0] a, input logic [1:0] k,
                                    input logic s, input logic l);
    logic [8:0] w;
    bit ok;
    if (a < BASE || a >= BASE + (NP << PLG)) return 0;
    w = m_perm[(a - BASE) >> PLG];
    case (k)
      2'd0: ok = s ? w[5] : w[2];
      2'd1: ok = s ? w[4] : w[1];
      2'd2: ok = s ? w[3] : w[0];
      default: ok = 0;
    endcase
    if (l && !w[8]) ok = 0;
    return !ok;
  endfunction

  task automatic cycle(input bit av, input logic [31:0] a, input logic [1:0] k,
                       input logic s, input logic l, input bit we,
                       input logic [6:0] wa, input logic [31:0] wd, input int req);
    bit d, clr, held;
    @(negedge clk);
    acc_valid = av; acc_addr = a; acc_kind = k; acc_super = s; acc_local = l;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    d = av && model_deny(a, k, s, l);
    clr = we && wa == 7'h42;
    held = clr ? 1'b0 : m_fsr[4];
    @(posedge clk);
    if (av) begin exp_q.push_back(d); req_q.push_back(req); end
    if (d && !held) begin m_far = a; m_fsr = {1'b1, l, s, k}; end
    else if (clr) begin m_far = 0; m_fsr = 0; end
    if (we && !wa[6] && wa[5:0] < NP) m_perm[wa[3:0]] = {wd[8], 2'b00, wd[5:0]};
    @(negedge clk);
    acc_valid = 0; cfg_we = 0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic s,
                     input logic l, input int req);
    cycle(1, a, k, s, l, 0, 0, 0, req);
  endtask
  task automatic wr(input logic [6:0] wa, input logic [31:0] wd);
    cycle(0, 0, 0, 0, 0, 1, wa, wd, 0);
  endtask
  task automatic rd(input logic [6:0] ra, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = ra; #1;
    check(req, cfg_rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) m_perm[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    rd(7'h00, 0, "R1 perm0");
    rd(7'h40, 0, "R1 far");
    rd(7'h41, 0, "R1 fsr");
    check("R1 pulse", 32'(fault_pulse), 0);
    // R2 layout and unused slots
    wr(7'h03, 32'hFFFF_FFFF);
    rd(7'h03, 32'h13F, "R2 masked");
    wr(7'h14, 32'h1FF);
    rd(7'h14, 0, "R2 unused slot");
    rd(7'h04, 0, "R2 alias untouched");
    // R3 user rights: page 1 user read + local
    wr(7'h01, 32'h104);
    acc(BASE + 32'h100, 2'd0, 0, 1, 3);
    acc(BASE + 32'h104, 2'd1, 0, 1, 3);
    rd(7'h40, BASE + 32'h104, "R8 far first");
    rd(7'h41, 32'h19, "R8 fsr first");
    acc(BASE + 32'h108, 2'd2, 1, 0, 4);
    rd(7'h40, BASE + 32'h104, "R8 far kept");
    rd(7'h41, 32'h19, "R8 fsr kept");
    acc(BASE + 32'h110, 2'd3, 0, 1, 3);
    // R4 supervisor rights: page 3 full
    acc(BASE + 32'h300, 2'd1, 1, 1, 4);
    acc(BASE + 32'h3FC, 2'd2, 1, 1, 4);
    wr(7'h05, 32'h010);
    acc(BASE + 32'h500, 2'd1, 1, 0, 4);
    acc(BASE + 32'h500, 2'd0, 1, 0, 4);
    // R9 clear
    wr(7'h42, 0);
    rd(7'h40, 0, "R9 far cleared");
    rd(7'h41, 0, "R9 fsr cleared");
    // R5 local gate: page 2 all mode bits, no local
    wr(7'h02, 32'h03F);
    acc(BASE + 32'h200, 2'd0, 0, 0, 5);
    acc(BASE + 32'h200, 2'd0, 0, 1, 5);
    rd(7'h41, 32'h18, "R5 fsr local");
    wr(7'h42, 0);
    // R7 outside window, zero perms everywhere around
    acc(BASE - 1, 2'd1, 0, 1, 7);
    acc(BASE + (NP << PLG), 2'd1, 0, 1, 7);
    rd(7'h41, 0, "R7 nothing captured");
    // R11 last byte uses page 15
    acc(BASE + (NP << PLG) - 1, 2'd0, 1, 1, 11);
    rd(7'h40, BASE + (NP << PLG) - 1, "R11 far last");
    wr(7'h0F, 32'h120);
    // R9 clear in same cycle as denied access: new capture
    cycle(1, BASE + 32'h500, 2'd2, 0, 0, 1, 7'h42, 0, 9);
    rd(7'h40, BASE + 32'h500, "R9 recapture far");
    rd(7'h41, 32'h12, "R9 recapture fsr");
    acc(BASE + (NP << PLG) - 1, 2'd0, 1, 1, 11);
    wr(7'h42, 0);
    // R10 write same cycle as access: old word used
    cycle(1, BASE + 32'h600, 2'd0, 0, 0, 1, 7'h06, 32'h004, 10);
    acc(BASE + 32'h600, 2'd0, 0, 0, 10);
    cycle(1, BASE + 32'h600, 2'd0, 0, 0, 1, 7'h06, 32'h000, 10);
    acc(BASE + 32'h600, 2'd0, 0, 0, 10);
    rd(7'h40, BASE + 32'h600, "R10 far");
    // R6 pulse lasts one cycle
    @(negedge clk);
    check("R6 pulse single", 32'(fault_pulse), 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule